// File: doc/BRIEF.md
# Trap entry sequencer

This block performs the status bookkeeping of a processor core when a trap is taken. Each cycle it receives one already-chosen trap request: its class, whether the trap is precise, and an 8-bit handler offset. It also receives the current PC, the PC of the previous instruction packet and the base field of the trap base register. In the next cycle it presents the updated supervisor, previous-supervisor and trap-enable bits, the saved PC, the new trap base value and a one-cycle load strobe for the new PC.

Break traps have their own save area: a break PC and a break copy of the supervisor and trap-enable bits. Break traps also raise a debug flag. A program or software trap that arrives while traps are disabled stops the core. An external trap in that state is dropped. Hardware and software reset requests are examined ahead of any trap. The reset vector is either the low address or a high address, chosen by a select input. A plain status write port lets return-from-trap logic restore the supervisor and trap-enable bits.

Top module: `trap_entry_seq`

## Requirements
- R1: While `rst_n` is low, and right after it is released, the outputs are: `st_super`=1, and `st_psuper`, `st_tren`, `dbg_flag`, `stopped`, `brk_super`, `brk_tren`, `pc_load` all 0. `save_pc`, `brk_pc`, `tbr_out` and `pc_out` are all zero.
- R2: A taken trap of class program (code 0), software (code 1) or external (code 2) is one with `st_tren`=1. At the next edge it copies `st_super` into `st_psuper`, sets `st_super` and clears `st_tren`.
- R3: On such a trap, `save_pc` takes `prev_pc` when `req_precise`=1 and `cur_pc` when `req_precise`=0.
- R4: On a taken trap, `tbr_out` becomes {`tbr_base`, `req_offset`, 4'h0}, with the offset in bits [11:4]. `pc_out` takes the same value, and `pc_load` is 1 for exactly that one cycle.
- R5: A program or software request while `st_tren`=0 sets `stopped`. In that case `pc_load` stays 0, and the status bits and `save_pc` keep their values.
- R6: An external request (code 2) while `st_tren`=0 has no effect: status, `stopped`, `save_pc`, `tbr_out` and `pc_load` are unchanged.
- R7: A break request (code 3) is taken whatever the value of `st_tren`. `brk_super` and `brk_tren` capture the old `st_super` and `st_tren`, and `brk_pc` captures `cur_pc`. Then `st_super`=1, `st_tren`=0, `dbg_flag`=1, and the offset field of `tbr_out` becomes 8'hFF. `pc_out` loads `tbr_out`. `st_psuper` and `save_pc` are not changed.
- R8: A reset request takes precedence over any trap request in the same cycle. When `rst_hard` and `rst_soft` are both 1, the hardware reset is the one performed.
- R9: On either reset request, `pc_out` becomes 32'hFF000000 if `rst_hi_vec`=1 and 0 otherwise, with `pc_load`=1. The status bits return to their R1 values, and `dbg_flag` and `stopped` are cleared.
- R10: A hardware reset request also clears `save_pc`, `brk_pc`, `brk_super`, `brk_tren` and `tbr_out`. A software reset request keeps them.
- R11: While `stopped`=1 and no reset is requested, trap requests and status writes are ignored.
- R12: With no taken trap, `st_wr`=1 loads `st_super` from `st_wr_super` and `st_tren` from `st_wr_tren` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A trap request is present |
| req_class | input | 2 | 0 program, 1 software, 2 external, 3 break |
| req_precise | input | 1 | Trap is precise |
| req_offset | input | 8 | Handler offset (trap type) |
| cur_pc | input | 32 | Current PC |
| prev_pc | input | 32 | PC of the previous instruction packet |
| tbr_base | input | 20 | Base field of the trap base register |
| rst_hard | input | 1 | Hardware reset request |
| rst_soft | input | 1 | Software reset request |
| rst_hi_vec | input | 1 | Select the high reset vector |
| st_wr | input | 1 | Status write strobe |
| st_wr_super | input | 1 | Supervisor value to write |
| st_wr_tren | input | 1 | Trap-enable value to write |
| st_super | output | 1 | Supervisor bit |
| st_psuper | output | 1 | Previous-supervisor bit |
| st_tren | output | 1 | Trap-enable bit |
| dbg_flag | output | 1 | Debug flag set by break |
| stopped | output | 1 | Core stopped |
| brk_super | output | 1 | Supervisor bit saved by break |
| brk_tren | output | 1 | Trap-enable bit saved by break |
| save_pc | output | 32 | Saved PC for program, software and external traps |
| brk_pc | output | 32 | Saved PC for break |
| tbr_out | output | 32 | Updated trap base register |
| pc_out | output | 32 | New PC |
| pc_load | output | 1 | New PC is valid this cycle |

## Verification
Every trap, reset and status-write result appears at the first rising edge after the request is presented, so it is due exactly one cycle after the stimulus. `pc_load` is high during that cycle only. The reset state is present as soon as `rst_n` is low. The driver applies each stimulus at a falling edge and queues the expected outputs. The monitor pops that entry 1 ns after the following rising edge, so every comparison falls in the one cycle where the result is due. It is never taken a cycle late or on a stale value. Idle cycles that follow loads are queued as well, which confirms that the strobe drops and that held registers stay put.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [1:0] {
    TC_PROG = 2'd0,
    TC_SOFT = 2'd1,
    TC_EXT  = 2'd2,
    TC_BRK  = 2'd3
  } trap_class_e;

  typedef enum logic [2:0] {
    ACT_NONE  = 3'd0,
    ACT_HRST  = 3'd1,
    ACT_SRST  = 3'd2,
    ACT_TRAP  = 3'd3,
    ACT_BREAK = 3'd4,
    ACT_HALT  = 3'd5,
    ACT_WRITE = 3'd6
  } trap_act_e;

endpackage

// File: rtl/trap_decide.sv
module trap_decide
  import trap_pkg::*;
(
  input  logic        req_valid,
  input  trap_class_e req_class,
  input  logic        tren,
  input  logic        stopped,
  input  logic        rst_hard,
  input  logic        rst_soft,
  input  logic        st_wr,
  output trap_act_e   act
);

  always_comb begin
    act = ACT_NONE;
    if (rst_hard) begin
      act = ACT_HRST;
    end else if (rst_soft) begin
      act = ACT_SRST;
    end else if (!stopped) begin
      if (req_valid && req_class == TC_BRK) begin
        act = ACT_BREAK;
      end else if (req_valid && tren) begin
        act = ACT_TRAP;
      end else if (req_valid && req_class != TC_EXT) begin
        act = ACT_HALT;
      end else if (st_wr) begin
        act = ACT_WRITE;
      end
    end
  end

endmodule

// File: rtl/trap_status.sv
module trap_status
  import trap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  trap_act_e act,
  input  logic      wr_super,
  input  logic      wr_tren,
  output logic      super_q,
  output logic      psuper_q,
  output logic      tren_q,
  output logic      dbg_q,
  output logic      stop_q,
  output logic      bsuper_q,
  output logic      btren_q
);

  logic super_d, psuper_d, tren_d, dbg_d, stop_d, bsuper_d, btren_d;
  logic upd_en;

  assign upd_en = (act != ACT_NONE);

  always_comb begin
    super_d  = super_q;
    psuper_d = psuper_q;
    tren_d   = tren_q;
    dbg_d    = dbg_q;
    stop_d   = stop_q;
    bsuper_d = bsuper_q;
    btren_d  = btren_q;
    unique case (act)
      ACT_HRST, ACT_SRST: begin
        super_d  = 1'b1;
        psuper_d = 1'b0;
        tren_d   = 1'b0;
        dbg_d    = 1'b0;
        stop_d   = 1'b0;
        if (act == ACT_HRST) begin
          bsuper_d = 1'b0;
          btren_d  = 1'b0;
        end
      end
      ACT_TRAP: begin
        psuper_d = super_q;
        super_d  = 1'b1;
        tren_d   = 1'b0;
      end
      ACT_BREAK: begin
        bsuper_d = super_q;
        btren_d  = tren_q;
        super_d  = 1'b1;
        tren_d   = 1'b0;
        dbg_d    = 1'b1;
      end
      ACT_HALT: begin
        stop_d = 1'b1;
      end
      ACT_WRITE: begin
        super_d = wr_super;
        tren_d  = wr_tren;
      end
      default: begin
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      super_q  <= 1'b1;
      psuper_q <= 1'b0;
      tren_q   <= 1'b0;
      dbg_q    <= 1'b0;
      stop_q   <= 1'b0;
      bsuper_q <= 1'b0;
      btren_q  <= 1'b0;
    end else if (upd_en) begin
      super_q  <= super_d;
      psuper_q <= psuper_d;
      tren_q   <= tren_d;
      dbg_q    <= dbg_d;
      stop_q   <= stop_d;
      bsuper_q <= bsuper_d;
      btren_q  <= btren_d;
    end
  end

endmodule

// File: rtl/trap_vector.sv
module trap_vector
  import trap_pkg::*;
#(
  parameter int unsigned      XLEN   = 32,
  parameter int unsigned      TT_W   = 8,
  parameter int unsigned      TT_LSB = 4,
  parameter logic [XLEN-1:0]  HI_VEC = 32'hFF00_0000,
  parameter logic [TT_W-1:0]  BRK_TT = 8'hFF
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  trap_act_e                       act,
  input  logic                            precise,
  input  logic [TT_W-1:0]                 offset,
  input  logic [XLEN-1:0]                 cur_pc,
  input  logic [XLEN-1:0]                 prev_pc,
  input  logic [XLEN-TT_LSB-TT_W-1:0]     tbr_base,
  input  logic                            hi_vec_sel,
  output logic [XLEN-1:0]                 save_q,
  output logic [XLEN-1:0]                 bpc_q,
  output logic [XLEN-1:0]                 tbr_q,
  output logic [XLEN-1:0]                 pc_q,
  output logic                            pcl_q
);

  logic [XLEN-1:0] trap_tbr, brk_tbr, rst_vec;
  logic [XLEN-1:0] save_d, bpc_d, tbr_d, pc_d;
  logic            pcl_d;
  logic            upd_en;

  generate
    if (TT_LSB > 0) begin : g_pad
      assign trap_tbr = {tbr_base, offset, {TT_LSB{1'b0}}};
      assign brk_tbr  = {tbr_base, BRK_TT, {TT_LSB{1'b0}}};
    end else begin : g_nopad
      assign trap_tbr = {tbr_base, offset};
      assign brk_tbr  = {tbr_base, BRK_TT};
    end
  endgenerate

  assign rst_vec = hi_vec_sel ? HI_VEC : '0;
  assign upd_en  = (act != ACT_NONE) || pcl_q;

  always_comb begin
    save_d = save_q;
    bpc_d  = bpc_q;
    tbr_d  = tbr_q;
    pc_d   = pc_q;
    pcl_d  = 1'b0;
    unique case (act)
      ACT_HRST: begin
        save_d = '0;
        bpc_d  = '0;
        tbr_d  = '0;
        pc_d   = rst_vec;
        pcl_d  = 1'b1;
      end
      ACT_SRST: begin
        pc_d  = rst_vec;
        pcl_d = 1'b1;
      end
      ACT_TRAP: begin
        save_d = precise ? prev_pc : cur_pc;
        tbr_d  = trap_tbr;
        pc_d   = trap_tbr;
        pcl_d  = 1'b1;
      end
      ACT_BREAK: begin
        bpc_d = cur_pc;
        tbr_d = brk_tbr;
        pc_d  = brk_tbr;
        pcl_d = 1'b1;
      end
      default: begin
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      save_q <= '0;
      bpc_q  <= '0;
      tbr_q  <= '0;
      pc_q   <= '0;
      pcl_q  <= 1'b0;
    end else if (upd_en) begin
      save_q <= save_d;
      bpc_q  <= bpc_d;
      tbr_q  <= tbr_d;
      pc_q   <= pc_d;
      pcl_q  <= pcl_d;
    end
  end

endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_pkg::*;
#(
  parameter int unsigned     XLEN   = 32,
  parameter int unsigned     TT_W   = 8,
  parameter int unsigned     TT_LSB = 4,
  parameter logic [XLEN-1:0] HI_VEC = 32'hFF00_0000,
  parameter logic [TT_W-1:0] BRK_TT = 8'hFF,
  localparam int unsigned    BASE_W = XLEN - TT_LSB - TT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_class,
  input  logic              req_precise,
  input  logic [TT_W-1:0]   req_offset,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   prev_pc,
  input  logic [BASE_W-1:0] tbr_base,
  input  logic              rst_hard,
  input  logic              rst_soft,
  input  logic              rst_hi_vec,
  input  logic              st_wr,
  input  logic              st_wr_super,
  input  logic              st_wr_tren,
  output logic              st_super,
  output logic              st_psuper,
  output logic              st_tren,
  output logic              dbg_flag,
  output logic              stopped,
  output logic              brk_super,
  output logic              brk_tren,
  output logic [XLEN-1:0]   save_pc,
  output logic [XLEN-1:0]   brk_pc,
  output logic [XLEN-1:0]   tbr_out,
  output logic [XLEN-1:0]   pc_out,
  output logic              pc_load
);

  trap_act_e act;

  trap_decide u_decide (
    .req_valid (req_valid),
    .req_class (trap_class_e'(req_class)),
    .tren      (st_tren),
    .stopped   (stopped),
    .rst_hard  (rst_hard),
    .rst_soft  (rst_soft),
    .st_wr     (st_wr),
    .act       (act)
  );

  trap_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (act),
    .wr_super (st_wr_super),
    .wr_tren  (st_wr_tren),
    .super_q  (st_super),
    .psuper_q (st_psuper),
    .tren_q   (st_tren),
    .dbg_q    (dbg_flag),
    .stop_q   (stopped),
    .bsuper_q (brk_super),
    .btren_q  (brk_tren)
  );

  trap_vector #(
    .XLEN   (XLEN),
    .TT_W   (TT_W),
    .TT_LSB (TT_LSB),
    .HI_VEC (HI_VEC),
    .BRK_TT (BRK_TT)
  ) u_vector (
    .clk        (clk),
    .rst_n      (rst_n),
    .act        (act),
    .precise    (req_precise),
    .offset     (req_offset),
    .cur_pc     (cur_pc),
    .prev_pc    (prev_pc),
    .tbr_base   (tbr_base),
    .hi_vec_sel (rst_hi_vec),
    .save_q     (save_pc),
    .bpc_q      (brk_pc),
    .tbr_q      (tbr_out),
    .pc_q       (pc_out),
    .pcl_q      (pc_load)
  );

endmodule

// File: rtl/trap_entry_seq_chk.sv
module trap_entry_seq_chk #(
  parameter int unsigned     XLEN   = 32,
  parameter int unsigned     TT_W   = 8,
  parameter int unsigned     TT_LSB = 4,
  parameter logic [XLEN-1:0] HI_VEC = 32'hFF00_0000,
  parameter logic [TT_W-1:0] BRK_TT = 8'hFF
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [1:0]      req_class,
  input logic            rst_hard,
  input logic            rst_soft,
  input logic            rst_hi_vec,
  input logic            st_wr,
  input logic            st_super,
  input logic            st_psuper,
  input logic            st_tren,
  input logic            dbg_flag,
  input logic            stopped,
  input logic [XLEN-1:0] tbr_out,
  input logic [XLEN-1:0] pc_out,
  input logic            pc_load
);

  logic no_rst;
  assign no_rst = !rst_hard && !rst_soft;

  a_r2_trap_status: assert property (@(posedge clk) disable iff (!rst_n)
    (no_rst && !stopped && req_valid && req_class != 2'd3 && st_tren)
    |=> (st_super && !st_tren && st_psuper == $past(st_super) && pc_load));

  a_r5_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (no_rst && !stopped && req_valid && req_class[1] == 1'b0 && !st_tren)
    |=> (stopped && !pc_load));

  a_r6_ext_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (no_rst && !stopped && !st_wr && req_valid && req_class == 2'd2 && !st_tren)
    |=> ($stable(st_super) && $stable(st_tren) && $stable(st_psuper) && !stopped && !pc_load));

  a_r7_break_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (no_rst && !stopped && req_valid && req_class == 2'd3)
    |=> (dbg_flag && st_super && !st_tren && pc_out == tbr_out
         && tbr_out[TT_LSB +: TT_W] == BRK_TT));

  a_r9_reset_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_hard || rst_soft)
    |=> (pc_load && !stopped && !dbg_flag && st_super && !st_tren
         && pc_out == ($past(rst_hi_vec) ? HI_VEC : '0)));

  a_r11_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && no_rst)
    |=> (stopped && $stable(st_super) && $stable(st_tren) && !pc_load));

endmodule

bind trap_entry_seq trap_entry_seq_chk #(
  .XLEN   (XLEN),
  .TT_W   (TT_W),
  .TT_LSB (TT_LSB),
  .HI_VEC (HI_VEC),
  .BRK_TT (BRK_TT)
) u_chk (.*);

// File: tb/trap_entry_seq_test.sv
`timescale 1ns/1ps
module trap_entry_seq_test;

  typedef struct {
    logic        s, ps, et, dbg, stp, bs, bet, pcl;
    logic [31:0] save, bpc, tbr, pc;
  } exp_t;

  logic        clk, rst_n;
  logic        req_valid, req_precise;
  logic [1:0]  req_class;
  logic [7:0]  req_offset;
  logic [31:0] cur_pc, prev_pc;
  logic [19:0] tbr_base;
  logic        rst_hard, rst_soft, rst_hi_vec;
  logic        st_wr, st_wr_super, st_wr_tren;
  logic        st_super, st_psuper, st_tren, dbg_flag, stopped, brk_super, brk_tren;
  logic [31:0] save_pc, brk_pc, tbr_out, pc_out;
  logic        pc_load;

  int checks = 0;
  int errors = 0;
  exp_t  m;
  exp_t  q[$];
  string tq[$];

  trap_entry_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
    .req_precise(req_precise), .req_offset(req_offset), .cur_pc(cur_pc),
    .prev_pc(prev_pc), .tbr_base(tbr_base), .rst_hard(rst_hard),
    .rst_soft(rst_soft), .rst_hi_vec(rst_hi_vec), .st_wr(st_wr),
    .st_wr_super(st_wr_super), .st_wr_tren(st_wr_tren), .st_super(st_super),
    .st_psuper(st_psuper), .st_tren(st_tren), .dbg_flag(dbg_flag),
    .stopped(stopped), .brk_super(brk_super), .brk_tren(brk_tren),
    .save_pc(save_pc), .brk_pc(brk_pc), .tbr_out(tbr_out), .pc_out(pc_out),
    .pc_load(pc_load)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic field(input string tag, input string name,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, name, act, exp);
    end
  endtask

  task automatic compare(input string tag, input exp_t e);
    field(tag, "st_super",  {31'd0, st_super},  {31'd0, e.s});
    field(tag, "st_psuper", {31'd0, st_psuper}, {31'd0, e.ps});
    field(tag, "st_tren",   {31'd0, st_tren},   {31'd0, e.et});
    field(tag, "dbg_flag",  {31'd0, dbg_flag},  {31'd0, e.dbg});
    field(tag, "stopped",   {31'd0, stopped},   {31'd0, e.stp});
    field(tag, "brk_super", {31'd0, brk_super}, {31'd0, e.bs});
    field(tag, "brk_tren",  {31'd0, brk_tren},  {31'd0, e.bet});
    field(tag, "pc_load",   {31'd0, pc_load},   {31'd0, e.pcl});
    field(tag, "save_pc", save_pc, e.save);
    field(tag, "brk_pc",  brk_pc,  e.bpc);
    field(tag, "tbr_out", tbr_out, e.tbr);
    field(tag, "pc_out",  pc_out,  e.pc);
  endtask

  // Expected outputs derived from the requirement list.
  task automatic model();
    logic [31:0] t;
    m.pcl = 1'b0;
    if (rst_hard || rst_soft) begin                      // R8, R9, R10
      m.pcl = 1'b1;
      m.pc  = rst_hi_vec ? 32'hFF00_0000 : 32'h0;
      m.s = 1'b1; m.ps = 1'b0; m.et = 1'b0; m.dbg = 1'b0; m.stp = 1'b0;
      if (rst_hard) begin
        m.save = '0; m.bpc = '0; m.tbr = '0; m.bs = 1'b0; m.bet = 1'b0;
      end
    end else if (m.stp) begin                            // R11
    end else if (req_valid && req_class == 2'd3) begin   // R7
      m.bs = m.s; m.bet = m.et; m.bpc = cur_pc;
      m.s = 1'b1; m.et = 1'b0; m.dbg = 1'b1;
      t = {tbr_base, 8'hFF, 4'h0};
      m.tbr = t; m.pc = t; m.pcl = 1'b1;
    end else if (req_valid && m.et) begin                // R2, R3, R4
      m.ps = m.s; m.s = 1'b1; m.et = 1'b0;
      m.save = req_precise ? prev_pc : cur_pc;
      t = {tbr_base, req_offset, 4'h0};
      m.tbr = t; m.pc = t; m.pcl = 1'b1;
    end else if (req_valid && req_class != 2'd2) begin   // R5
      m.stp = 1'b1;
    end else if (st_wr) begin                            // R12
      m.s = st_wr_super; m.et = st_wr_tren;
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] c, input logic p,
                       input logic [7:0] off, input logic [31:0] cpc,
                       input logic [31:0] ppc, input logic [19:0] base,
                       input logic hr, input logic sr, input logic hv,
                       input logic w, input logic ws, input logic we,
                       input string tag);
    @(negedge clk);
    req_valid = v; req_class = c; req_precise = p; req_offset = off;
    cur_pc = cpc; prev_pc = ppc; tbr_base = base;
    rst_hard = hr; rst_soft = sr; rst_hi_vec = hv;
    st_wr = w; st_wr_super = ws; st_wr_tren = we;
    model();
    q.push_back(m);
    tq.push_back(tag);
  endtask

  task automatic idle(input string tag);
    drive(1'b0, 2'd0, 1'b0, 8'h00, 32'h0, 32'h0, 20'h0,
          1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic wr(input logic s, input logic e, input string tag);
    drive(1'b0, 2'd0, 1'b0, 8'h00, 32'h0, 32'h0, 20'h0,
          1'b0, 1'b0, 1'b0, 1'b1, s, e, tag);
  endtask

  // Monitor: pops one expected item 1 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() != 0) begin
        exp_t  e;
        string t;
        e = q.pop_front();
        t = tq.pop_front();
        compare(t, e);
      end
    end
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_class = 2'd0; req_precise = 1'b0; req_offset = '0;
    cur_pc = '0; prev_pc = '0; tbr_base = '0;
    rst_hard = 1'b0; rst_soft = 1'b0; rst_hi_vec = 1'b0;
    st_wr = 1'b0; st_wr_super = 1'b0; st_wr_tren = 1'b0;
    m.s = 1'b1; m.ps = 1'b0; m.et = 1'b0; m.dbg = 1'b0; m.stp = 1'b0;
    m.bs = 1'b0; m.bet = 1'b0; m.pcl = 1'b0;
    m.save = '0; m.bpc = '0; m.tbr = '0; m.pc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 in reset", m);
    rst_n = 1'b1;
    #1;
    compare("R1 after release", m);

    // R6: external with traps disabled is dropped
    drive(1'b1, 2'd2, 1'b0, 8'h2A, 32'h0000_0500, 32'h0000_04F8, 20'h11111,
          1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 ext ignored");
    // R12: status write
    wr(1'b0, 1'b1, "R12 status write");
    // R2 R3 R4: precise program trap
    drive(1'b1, 2'd0, 1'b1, 8'h12, 32'h0000_1000, 32'h0000_0FF8, 20'hABCDE,
          1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 precise program");
    idle("R4 strobe drops");
    // R2 R3: imprecise external from supervisor mode
    wr(1'b1, 1'b1, "R12 status write 2");
    drive(1'b1, 2'd2, 1'b0, 8'h2F, 32'h0000_2000, 32'h0000_1FF0, 20'h12345,
          1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 imprecise external");
    // R2: software trap from user mode
    wr(1'b0, 1'b1, "R12 status write 3");
    drive(1'b1, 2'd1, 1'b0, 8'h80, 32'h0000_3004, 32'h0000_3000, 20'h0F0F0,
          1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 software trap");
    // R7: break with traps disabled, then with traps enabled from user mode
    drive(1'b1, 2'd3, 1'b0, 8'h33, 32'h0000_4000, 32'h0000_3FF8, 20'hCAFEB,
          1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 break tren0");
    wr(1'b0, 1'b1, "R12 status write 4");
    drive(1'b1, 2'd3, 1'b1, 8'h44, 32'h0000_5008, 32'h0000_5000, 20'h00001,
          1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 break tren1");
    idle("R7 idle hold");
    // R8 R9 R10: soft reset beats trap, high vector, save area kept
    drive(1'b1, 2'd0, 1'b0, 8'h55, 32'h0000_6000, 32'h0000_5FF8, 20'h77777,
          1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R8 soft reset wins");
    idle("R9 strobe drops");
    // R5: program trap with traps disabled stops the core
    drive(1'b1, 2'd0, 1'b1, 8'h66, 32'h0000_7000, 32'h0000_6FF8, 20'h22222,
          1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 halt");
    // R11: stopped ignores traps and writes
    drive(1'b1, 2'd3, 1'b0, 8'h01, 32'h0000_8000, 32'h0000_7FF8, 20'h33333,
          1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R11 break while stopped");
    wr(1'b0, 1'b1, "R11 write while stopped");
    // R8 R9 R10: hard beats soft, low vector, save area cleared
    drive(1'b1, 2'd1, 1'b0, 8'h77, 32'h0000_9000, 32'h0000_8FF8, 20'h44444,
          1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R10 hard reset");
    idle("R1 post hard reset");
    // R5: software trap halts too
    drive(1'b1, 2'd1, 1'b0, 8'h09, 32'h0000_A000, 32'h0000_9FF8, 20'h55555,
          1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 software halt");
    idle("R11 stopped idle");
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule